// File: doc/BRIEF.md
# SPI Flash Command Controller

This block is a register-driven SPI master for serial NOR flash parts. A processor programs it through five 32-bit registers: a mode register, a command register, a status register, a transmit word and a receive word. In software mode it shifts out a raw command of one to four bytes, taken from the transmit word starting at its lowest byte, and can then clock in up to three response bytes, which land at the low end of the receive word.

Two trigger bits in the command register run the most frequent flash housekeeping opcodes without software having to build them: one fetches the flash status byte (opcode 0x05) and stores it in the low byte of the controller's own status register, and the other sends the write-enable opcode (0x06). Every finished transaction sets a sticky done flag that software clears explicitly. The bus runs in SPI mode 3 with the serial clock derived from the system clock by a fixed even divider, and any one of four chip selects can be chosen per transaction.

Top module: `spi_cmd_ctrl`

## Requirements
- R1: After reset every chip select is high, the serial clock is high, the data output is 0, and all five registers read 0.
- R2: The serial clock idles high, one serial clock period is DIV system clocks, the data output changes only together with a falling serial clock edge and the input is sampled on the rising edge; each byte goes out most significant bit first.
- R3: Writing the command register (offset 0x04) with bit 7 set while software mode is on sends bytes of the transmit word (offset 0x0C) lowest byte first; bits 2:0 give the byte count 1 to 4, values 5 to 7 act as 4, and 0 makes the start ignored.
- R4: Bits 6:4 of the command register give the number of response bytes clocked in after the command (0 to 3, values above 3 act as 3); at completion of a software transfer the receive word (offset 0x10) holds the first response byte in bits 7:0, the next in 15:8 and 23:16, and zero in every unused bit.
- R5: With software mode off (mode register offset 0x00, bit 28 clear) a command write with only bit 7 set starts nothing and leaves the done flag unchanged.
- R6: Command bit 10 sends opcode 0x05, clocks in one byte and stores it in status bits 7:0 (bit 0 write in progress, bit 1 write-enable latch), independent of software mode; it takes precedence over bits 11 and 7, and the receive word is left unchanged.
- R7: Command bit 11 (without bit 10) sends the single byte 0x06 with no response phase, independent of software mode, and takes precedence over bit 7.
- R8: Command bits 13:12 select which of the four active-low chip selects (bit n of the output for value n) is driven low; at most one is low and it stays unchanged for the whole transaction.
- R9: Status bit 8 is set when a transaction ends and stays set; a status write with bit 8 at 0 clears it and a write with bit 8 at 1 leaves it set.
- R10: A command register write made while a transaction is in progress is ignored entirely: no new transaction, stored fields unchanged.
- R11: The chip select falls half a serial clock period before the first falling clock edge and rises half a period after the last rising edge, at the same cycle the done flag is set.
- R12: The mode register reads back bits 28 (software mode) and 29 (write-burst mode) and zero elsewhere; the command register reads back fields 2:0, 6:4 and 13:12 with trigger bits reading 0; the transmit word reads back all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
On every cycle the assertions check the mode-3 pin discipline: a high idle clock, data held steady except at falling clock edges, one chip select low at a time and unchanged during a transaction, release with the clock high, and the done flag rising only at that release. The byte order on the wire, the clamping of the length fields, packing of response bytes, the precedence among the trigger bits and the way writes during a transaction or with software mode off are ignored need the bench's scenarios, whose queue model predicts every pin value cycle by cycle and the register contents afterwards.

// File: rtl/spi_cmd_pkg.sv
// Shared constants and types of the SPI flash command controller.
// Assumes byte offsets on a 5-bit register address.
package spi_cmd_pkg;
    localparam int REG_AW = 5;
    localparam logic [REG_AW-1:0] OFS_MODE   = 5'h00;
    localparam logic [REG_AW-1:0] OFS_CMD    = 5'h04;
    localparam logic [REG_AW-1:0] OFS_STATUS = 5'h08;
    localparam logic [REG_AW-1:0] OFS_TXW    = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_RXW    = 5'h10;

    localparam int MODE_SW_BIT    = 28;
    localparam int MODE_BURST_BIT = 29;
    localparam int CMD_GO_BIT     = 7;
    localparam int CMD_RDSR_BIT   = 10;
    localparam int CMD_WREN_BIT   = 11;
    localparam int CMD_CS_LSB     = 12;
    localparam int STAT_DONE_BIT  = 8;

    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_WREN = 8'h06;

    typedef enum logic [1:0] {K_NONE, K_RAW, K_RDSR, K_WREN} cmd_kind_t;

    typedef struct packed {
        logic [31:0] tx_word;
        logic [2:0]  tx_bytes;   // 1..4
        logic [1:0]  rx_bytes;   // 0..3
        logic [1:0]  cs_sel;
    } xfer_req_t;
endpackage

// File: rtl/spi_cmd_regs.sv
// Register file and command decoder. Turns command-register writes into
// transaction requests, keeps the sticky done flag and stores results.
// Assumes the shifter keeps its own copy of the request while busy.
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [23:0]       rx_data,
    output logic              start,
    output xfer_req_t         req,
    output logic              done_flag
);
    logic        sw_mode, burst_mode;
    logic [2:0]  f_tx, f_rx;
    logic [1:0]  f_cs;
    logic [31:0] tx_word;
    logic [23:0] rx_word;
    logic [7:0]  flash_stat;
    cmd_kind_t   kind_q, kind_d;
    logic        cmd_wr;

    assign cmd_wr = reg_we && (reg_addr == OFS_CMD) && !busy;

    // Decode a command write into a request, trigger bits by precedence.
    always_comb begin
        start  = 1'b0;
        kind_d = K_NONE;
        req    = '{tx_word: 32'd0, tx_bytes: 3'd1, rx_bytes: 2'd0,
                   cs_sel: reg_wdata[CMD_CS_LSB +: 2]};
        if (cmd_wr) begin
            if (reg_wdata[CMD_RDSR_BIT]) begin
                start = 1'b1; kind_d = K_RDSR;
                req.tx_word = {24'd0, OPC_RDSR}; req.rx_bytes = 2'd1;
            end else if (reg_wdata[CMD_WREN_BIT]) begin
                start = 1'b1; kind_d = K_WREN;
                req.tx_word = {24'd0, OPC_WREN};
            end else if (sw_mode && reg_wdata[CMD_GO_BIT] && reg_wdata[2:0] != 3'd0) begin
                start = 1'b1; kind_d = K_RAW;
                req.tx_word  = tx_word;
                req.tx_bytes = (reg_wdata[2:0] > 3'd4) ? 3'd4 : reg_wdata[2:0];
                req.rx_bytes = (reg_wdata[6:4] > 3'd3) ? 2'd3 : reg_wdata[5:4];
            end
        end
    end

    // Register updates, start bookkeeping and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_mode <= 1'b0; burst_mode <= 1'b0;
            f_tx <= '0; f_rx <= '0; f_cs <= '0;
            tx_word <= '0; rx_word <= '0; flash_stat <= '0;
            done_flag <= 1'b0; kind_q <= K_NONE;
        end else begin
            if (reg_we && reg_addr == OFS_MODE) begin
                sw_mode    <= reg_wdata[MODE_SW_BIT];
                burst_mode <= reg_wdata[MODE_BURST_BIT];
            end
            if (reg_we && reg_addr == OFS_TXW) tx_word <= reg_wdata;
            if (cmd_wr) begin
                f_tx <= reg_wdata[2:0];
                f_rx <= reg_wdata[6:4];
                f_cs <= reg_wdata[CMD_CS_LSB +: 2];
            end
            if (start) kind_q <= kind_d;
            if (reg_we && reg_addr == OFS_STATUS && !reg_wdata[STAT_DONE_BIT])
                done_flag <= 1'b0;
            if (done) begin
                done_flag <= 1'b1;
                if (kind_q == K_RDSR) flash_stat <= rx_data[7:0];
                if (kind_q == K_RAW)  rx_word    <= rx_data;
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            OFS_MODE:   reg_rdata = {2'b0, burst_mode, sw_mode, 28'd0};
            OFS_CMD:    reg_rdata = {18'd0, f_cs, 5'd0, f_rx, 1'b0, f_tx};
            OFS_STATUS: reg_rdata = {23'd0, done_flag, flash_stat};
            OFS_TXW:    reg_rdata = tx_word;
            OFS_RXW:    reg_rdata = {8'd0, rx_word};
            default:    reg_rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/spi_cmd_shifter.sv
// Mode-3 SPI shift engine. Sends tx_bytes from tx_word (low byte first,
// MSB first per byte), then samples rx_bytes into a 24-bit word.
// Assumes DIV is even and at least 2; start is honoured only when idle.
module spi_cmd_shifter
    import spi_cmd_pkg::*;
#(
    parameter int DIV    = 4,
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  xfer_req_t         req,
    input  logic              spi_miso,
    output logic              busy,
    output logic              done,
    output logic [23:0]       rx_data,
    output logic              spi_sck,
    output logic              spi_mosi,
    output logic [NUM_CS-1:0] spi_cs_n
);
    localparam int HALF  = DIV / 2;
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

    typedef enum logic [1:0] {S_IDLE, S_LEAD, S_LOW, S_HIGH} st_t;
    st_t              st;
    logic [CNT_W-1:0] cnt;
    logic [5:0]       bit_idx, nbits, txbits, rbit;
    logic [31:0]      txbuf;
    logic [NUM_CS-1:0] cs_pick;
    logic             cnt_end, last_bit;

    // One-hot-low chip select pattern for the requested select.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_pick[g] = (int'(req.cs_sel) != g);
    end

    assign cnt_end  = (cnt == CNT_LAST);
    assign last_bit = (bit_idx == nbits - 6'd1);
    assign rbit     = bit_idx - txbits;
    assign busy     = (st != S_IDLE);
    assign done     = (st == S_HIGH) && cnt_end && last_bit;
    assign spi_mosi = busy && (bit_idx < txbits) &&
                      txbuf[{bit_idx[4:3], ~bit_idx[2:0]}];

    // Half-period sequencer driving clock, selects and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; cnt <= '0; bit_idx <= '0; nbits <= '0;
            txbits <= '0; txbuf <= '0; rx_data <= '0;
            spi_sck <= 1'b1; spi_cs_n <= '1;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    txbuf    <= req.tx_word;
                    txbits   <= {req.tx_bytes, 3'b000};
                    nbits    <= {req.tx_bytes, 3'b000} + {1'b0, req.rx_bytes, 3'b000};
                    bit_idx  <= '0;
                    cnt      <= '0;
                    rx_data  <= '0;
                    spi_cs_n <= cs_pick;
                    st       <= S_LEAD;
                end
                S_LEAD: if (cnt_end) begin
                    cnt <= '0; spi_sck <= 1'b0; st <= S_LOW;
                end else cnt <= cnt + 1'b1;
                S_LOW: if (cnt_end) begin
                    cnt <= '0; spi_sck <= 1'b1; st <= S_HIGH;
                    if (bit_idx >= txbits)
                        rx_data[{rbit[4:3], ~rbit[2:0]}] <= spi_miso;
                end else cnt <= cnt + 1'b1;
                S_HIGH: if (cnt_end) begin
                    cnt <= '0;
                    if (last_bit) begin
                        spi_cs_n <= '1; bit_idx <= '0; st <= S_IDLE;
                    end else begin
                        spi_sck <= 1'b0; bit_idx <= bit_idx + 6'd1; st <= S_LOW;
                    end
                end else cnt <= cnt + 1'b1;
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_cmd_ctrl.sv
// Top of the SPI flash command controller: register file plus shifter.
// Assumes a single clock domain and a synchronous active-low reset.
module spi_cmd_ctrl
    import spi_cmd_pkg::*;
#(
    parameter int DIV    = 4,
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);
    logic        start, busy, done, done_flag;
    logic [23:0] rx_data;
    xfer_req_t   req;

    spi_cmd_regs u_regs (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .busy, .done, .rx_data, .start, .req, .done_flag
    );

    spi_cmd_shifter #(.DIV(DIV), .NUM_CS(NUM_CS)) u_shift (
        .clk, .rst_n, .start, .req, .spi_miso, .busy, .done, .rx_data,
        .spi_sck, .spi_mosi, .spi_cs_n
    );
endmodule

// File: rtl/spi_cmd_checker.sv
// Pin-level protocol checker for spi_cmd_ctrl, attached by bind.
module spi_cmd_checker #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CS-1:0] cs_n,
    input logic              sck,
    input logic              mosi,
    input logic              done_flag
);
    // R8: never more than one select low
    assert_one_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);
    // R8: the chosen select does not change mid-transaction
    assert_select_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && !$past(&cs_n)) |-> $stable(cs_n));
    // R2: clock idles high
    assert_idle_clock_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> sck);
    // R2: data moves only with a falling clock edge
    assert_data_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && !$past(&cs_n) && sck) |-> $stable(mosi));
    // R11: release happens with the clock high for a full cycle before
    assert_release_clock_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&cs_n) |-> (sck && $past(sck)));
    // R9 / R11: done flag rises exactly at the select release
    assert_done_at_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> ((&cs_n) && !$past(&cs_n)));
endmodule

bind spi_cmd_ctrl spi_cmd_checker #(.NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck),
    .mosi(spi_mosi), .done_flag(done_flag)
);

// File: tb/spi_cmd_ctrl_bench.sv
module spi_cmd_ctrl_bench;
    localparam int DIV_B  = 4;
    localparam int HALF_B = DIV_B / 2;

    logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, spi_miso = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        spi_sck, spi_mosi;
    logic [3:0]  spi_cs_n;

    always #4 clk = ~clk;   // 125 MHz

    spi_cmd_ctrl #(.DIV(DIV_B), .NUM_CS(4)) u_spi_cmd_ctrl (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .spi_sck, .spi_mosi, .spi_miso, .spi_cs_n
    );

    int checks = 0, failures = 0;
    bit finished = 0, mon_en = 0;
    string tag = "R1";

    // behavioural model state
    logic [5:0]  q[$];
    logic        resp_bits[64];
    int          fall_idx = 0;
    bit          m_sw = 0, m_burst = 0, m_tff = 0;
    logic [2:0]  m_ftx = 0, m_frx = 0;
    logic [1:0]  m_fcs = 0;
    logic [31:0] m_tx = 0;
    logic [23:0] m_rx = 0, pend_resp = 0;
    logic [7:0]  m_fstat = 0;
    int          pend_kind = 0, pend_rxb = 0;  // 0 none 1 raw 2 rdsr 3 wren

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    // flash model: next response bit on each falling clock while selected
    always @(negedge spi_sck) if (spi_cs_n != 4'hF) begin
        spi_miso <= resp_bits[fall_idx];
        fall_idx <= fall_idx + 1;
    end

    // per-cycle pin comparison against the queued expectation
    always @(negedge clk) if (mon_en) begin
        logic [5:0] e;
        e = (q.size() != 0) ? q.pop_front() : 6'b1111_1_0;
        chk({tag, " pins cs/sck/mosi"}, {26'd0, spi_cs_n, spi_sck, spi_mosi}, {26'd0, e});
    end

    function automatic logic [31:0] exp_reg(input logic [4:0] a);
        case (a)
            5'h00: return {2'b0, m_burst, m_sw, 28'd0};
            5'h04: return {18'd0, m_fcs, 5'd0, m_frx, 1'b0, m_ftx};
            5'h08: return {23'd0, m_tff, m_fstat};
            5'h0C: return m_tx;
            5'h10: return {8'd0, m_rx};
            default: return 32'd0;
        endcase
    endfunction

    task automatic rd(input logic [4:0] a, input string t);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(t, reg_rdata, exp_reg(a));
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [23:0] resp);
        int kind = 0, txb = 0, rxb = 0;
        logic [31:0] txw = 0;
        logic [3:0]  csv;
        @(negedge clk);
        if (a == 5'h04 && q.size() == 0) begin
            m_ftx = d[2:0]; m_frx = d[6:4]; m_fcs = d[13:12];
            if (d[10])      begin kind = 2; txw = 32'h05; txb = 1; rxb = 1; end
            else if (d[11]) begin kind = 3; txw = 32'h06; txb = 1; rxb = 0; end
            else if (m_sw && d[7] && d[2:0] != 0) begin
                kind = 1; txw = m_tx;
                txb = (d[2:0] > 4) ? 4 : int'(d[2:0]);
                rxb = (d[6:4] > 3) ? 3 : int'(d[6:4]);
            end
        end
        if (kind != 0) begin
            for (int i = 0; i < 64; i++) resp_bits[i] = 1'b0;
            for (int i = 0; i < rxb * 8; i++)
                resp_bits[txb * 8 + i] = resp[(i / 8) * 8 + 7 - (i % 8)];
            fall_idx = 0;
        end
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        if (a == 5'h00) begin m_sw = d[28]; m_burst = d[29]; end
        if (a == 5'h0C) m_tx = d;
        if (a == 5'h08 && !d[8]) m_tff = 0;
        if (kind != 0) begin
            csv = ~(4'b0001 << d[13:12]);
            for (int h = 0; h < HALF_B; h++) q.push_back({csv, 1'b1, txw[7]});
            for (int i = 0; i < (txb + rxb) * 8; i++) begin
                logic b;
                b = (i < txb * 8) ? txw[(i / 8) * 8 + 7 - (i % 8)] : 1'b0;
                for (int h = 0; h < HALF_B; h++) q.push_back({csv, 1'b0, b});
                for (int h = 0; h < HALF_B; h++) q.push_back({csv, 1'b1, b});
            end
            pend_kind = kind; pend_rxb = rxb; pend_resp = resp;
        end
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        if (pend_kind != 0) begin
            m_tff = 1;
            if (pend_kind == 2) m_fstat = pend_resp[7:0];
            if (pend_kind == 1) m_rx = pend_resp & ((24'd1 << (8 * pend_rxb)) - 24'd1);
            pend_kind = 0;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1;
        // R1: reset state
        tag = "R1";
        rd(5'h00, "R1 mode reg"); rd(5'h04, "R1 cmd reg"); rd(5'h08, "R1 status");
        rd(5'h0C, "R1 tx word"); rd(5'h10, "R1 rx word");
        // R12: readback masks
        tag = "R12";
        wr(5'h00, 32'hFFFF_FFFF, 0); rd(5'h00, "R12 mode readback");
        wr(5'h00, 32'h1000_0000, 0);
        wr(5'h0C, 32'hA5C3_0F9F, 0); rd(5'h0C, "R12 tx readback");
        // R3/R4: read-ID style 1+3, cs 2
        tag = "R3 R4 R2 R8 R11";
        wr(5'h0C, 32'h0000_009F, 0);
        wr(5'h04, 32'h0000_2031 | 32'h80, 24'h152017);
        wait_idle();
        rd(5'h10, "R4 rx packed 3 bytes"); rd(5'h08, "R9 done set");
        rd(5'h04, "R12 cmd fields, triggers read 0");
        // R9: write 1 keeps, write 0 clears
        tag = "R9";
        wr(5'h08, 32'h0000_0100, 0); rd(5'h08, "R9 write one keeps");
        wr(5'h08, 32'h0, 0);         rd(5'h08, "R9 write zero clears");
        // R3: 4-byte erase, no response, cs 1
        tag = "R3 R8";
        wr(5'h0C, 32'h5634_12D8, 0);
        wr(5'h04, 32'h0000_1084, 0);
        wait_idle(); rd(5'h10, "R4 no response bytes gives zero");
        // R3/R4 clamps: tx 7 -> 4, rx 7 -> 3, cs 3
        tag = "R3 R4 clamp";
        wr(5'h04, 32'h0000_30F7, 24'hE1D2C3);
        wait_idle(); rd(5'h10, "R4 rx clamp to 3");
        // R4: 2 response bytes, upper byte zero
        tag = "R4";
        wr(5'h0C, 32'h0000_3C0B, 0);
        wr(5'h04, 32'h0000_00A2, 24'hABCDEF);
        wait_idle(); rd(5'h10, "R4 upper byte zero");
        // R3: zero length ignored
        tag = "R3 zero length";
        wr(5'h08, 32'h0, 0);
        wr(5'h04, 32'h0000_0080, 0);
        repeat (10) @(negedge clk); rd(5'h08, "R3 zero length starts nothing");
        // R5: software mode off
        tag = "R5";
        wr(5'h00, 32'h0, 0);
        wr(5'h04, 32'h0000_0081, 0);
        repeat (10) @(negedge clk); rd(5'h08, "R5 go ignored without sw mode");
        rd(5'h10, "R5 rx word unchanged");
        // R6: read-status wins over 11 and 7, cs 3, sw mode off
        tag = "R6";
        wr(5'h04, 32'h0000_3E81, 24'h000003);
        wait_idle(); rd(5'h08, "R6 flash status in low byte");
        rd(5'h10, "R6 rx word untouched");
        // R7: write-enable wins over 7
        tag = "R7";
        wr(5'h00, 32'h1000_0000, 0);
        wr(5'h08, 32'h0, 0);
        wr(5'h04, 32'h0000_0884, 0);
        wait_idle(); rd(5'h08, "R7 done set, status byte kept");
        // R10: write during a transaction ignored
        tag = "R10";
        wr(5'h0C, 32'h1234_5678, 0);
        wr(5'h04, 32'h0000_00B4, 24'h665544);
        repeat (10) @(negedge clk);
        wr(5'h04, 32'h0000_3C00, 0);
        wait_idle(); rd(5'h04, "R10 fields kept from first write");
        rd(5'h10, "R10 first transfer completes");
        repeat (5) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule